// File: doc/BRIEF.md
# Preloadable Interval Timer

This block is a host-programmed interval timer. It raises an interrupt each time a programmed number of ticks has passed. A configuration word holds a run bit and a 16-bit reload value. Setting the run bit loads the counter from the reload value. While the timer runs, the counter counts down by one on every cycle in which the tick-enable input is high. When it reaches zero, a sticky status flag is set, and the next tick reloads the counter. Expiries therefore repeat with a period of reload+1 ticks.

The host reaches four word registers over a plain register bus. The bus has a word address, a write strobe, a read strobe, write data and registered read data. Clearing the run bit halts the counter where it stands. The same action forces the reload field back to all ones, whatever value was written alongside. The interrupt output is the status flag gated by an interrupt-enable bit.

Top module: `gp_interval_timer`

## Requirements
- R1: After reset, the config word reads 0x0000FFFF (run bit 0, reload FFFFh). The count, the status and the interrupt enable read 0, and irq_o is low.
- R2: The config word is at word address 0. The run bit is bit 29 and the reload value is bits 15:0. Bits 31:30 and 28:16 read zero and ignore writes.
- R3: A config write that takes the run bit from 1 to 0 sets the reload field to FFFFh. This takes priority over the reload value written in the same write.
- R4: A config write that takes the run bit from 0 to 1 loads the counter with the reload value from that write. A tick in the same cycle is ignored.
- R5: While running, each cycle with tick_i high lowers the count by one. Cycles with tick_i low leave it unchanged.
- R6: A tick that leaves the count at zero sets the status flag. A tick at count zero reloads the count from the reload field. The first expiry comes after reload ticks and later expiries come every reload+1 ticks.
- R7: The status flag is bit 0 at word address 2. It stays set until it is cleared by writing 1 there. Writing 0 has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R8: irq_o equals the status flag ANDed with the interrupt-enable bit, which is bit 0 at word address 3.
- R9: While halted, the counter holds its value regardless of tick_i. The live count reads at word address 1 in bits 15:0, with the upper bits zero.
- R10: A read strobe returns the addressed register on rdata_o one cycle later, and rdata_o holds between reads. A config write with run 0 while already halted stores the written reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one decrement per high cycle |
| addr_i | input | 2 | Word address of the register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that rd_i and wr_i are synchronous and single-cycle per access. They also assume that a config write and a tick in the same cycle follow the rule that the load wins. The bench drives every strobe and tick on the falling edge. It keeps each bus access to one cycle and samples registered read data one full cycle later. It deliberately overlaps a tick with an enabling write, and an expiry with a status clear, to reach the two priority cases. The reload sweep stays small, so each period can be walked tick by tick against an arithmetic model.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int DATA_W = 32;
  localparam int EN_BIT = 29;

  typedef enum logic [1:0] {
    REG_CFG = 2'd0,
    REG_CNT = 2'd1,
    REG_STS = 2'd2,
    REG_IE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step  = run_i && tick_i && !load_i;
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (step)  cnt_d = (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
    expire_o = step && (cnt_d == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q)); // R9
  AST_LOAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)); // R4
  AST_TICK_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !load_i && cnt_q == '0) |=> cnt_q == $past(reload_i)); // R6
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output logic              run_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              en_q, ie_q, sts_q;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic              cfg_wr, en_wr, sts_clr;
  logic [DATA_W-1:0] rd_mux;
  reg_sel_e          sel;
  logic              unused_wdata;

  assign sel          = reg_sel_e'(addr_i);
  assign unused_wdata = ^{wdata_i[DATA_W-1:EN_BIT+1], wdata_i[EN_BIT-1:CNT_W]};

  always_comb begin
    cfg_wr   = wr_i && (sel == REG_CFG);
    en_wr    = wdata_i[EN_BIT];
    load_o   = cfg_wr && !en_q && en_wr;
    sts_clr  = wr_i && (sel == REG_STS) && wdata_i[0];
    reload_d = reload_q;
    if (cfg_wr) reload_d = (en_q && !en_wr) ? '1 : wdata_i[CNT_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      REG_CFG: begin
        rd_mux[EN_BIT]    = en_q;
        rd_mux[CNT_W-1:0] = reload_q;
      end
      REG_CNT: rd_mux[CNT_W-1:0] = cnt_i;
      REG_STS: rd_mux[0] = sts_q;
      REG_IE:  rd_mux[0] = ie_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      reload_q <= '1;
      ie_q     <= 1'b0;
      sts_q    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      if (cfg_wr) en_q <= en_wr;
      reload_q <= reload_d;
      if (wr_i && sel == REG_IE) ie_q <= wdata_i[0];
      sts_q <= expire_i | (sts_q & ~sts_clr);
      if (rd_i) rdata_o <= rd_mux;
    end
  end

  assign run_o      = en_q;
  assign load_val_o = reload_d;
  assign reload_o   = reload_q;
  assign irq_o      = sts_q & ie_q;

  AST_FALL_FORCES_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> reload_q == '1); // R3
  AST_EXPIRE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> sts_q); // R6
  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !sts_clr) |=> sts_q); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel == REG_CFG) |=> (rdata_o[DATA_W-1:EN_BIT+1] == '0 && rdata_o[EN_BIT-1:CNT_W] == '0)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/gp_interval_timer.sv
module gp_interval_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             run, load, expire;
  logic [CNT_W-1:0] load_val, reload, cnt;

  gpt_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i,
    .cnt_i(cnt), .expire_i(expire), .run_o(run), .load_o(load),
    .load_val_o(load_val), .reload_o(reload), .rdata_o, .irq_o
  );

  gpt_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i, .rst_ni, .run_i(run), .load_i(load), .load_val_i(load_val),
    .reload_i(reload), .tick_i, .cnt_o(cnt), .expire_o(expire)
  );

  AST_IRQ_NEEDS_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(expire) || $past(wr_i && addr_i == 2'd3))); // R8
endmodule

// File: tb/test_gp_interval_timer.sv
`timescale 1ns/1ps
module test_gp_interval_timer;
  logic        clk = 0, rst_n = 0, tick = 0, wr = 0, rd = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, rv;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  gp_interval_timer i_gp_interval_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d, input logic tk = 0);
    @(negedge clk); addr = a; wdata = d; wr = 1; tick = tk;
    @(negedge clk); wr = 0; tick = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int rl [5] = '{0, 1, 2, 3, 6};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_rd(2'd0, rv); chk("R1 cfg", rv, 32'h0000FFFF);
    bus_rd(2'd1, rv); chk("R1 cnt", rv, 0);
    bus_rd(2'd2, rv); chk("R1 sts", rv, 0);
    bus_rd(2'd3, rv); chk("R1 ie", rv, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    // R10 halted write stores reload; rdata holds
    bus_wr(2'd0, 32'h0000_1234);
    bus_rd(2'd0, rv); chk("R10 halted store", rv, 32'h0000_1234);
    repeat (3) @(negedge clk);
    chk("R10 rdata hold", rdata, 32'h0000_1234);
    // R9 halted counter ignores ticks
    tick_once(); tick_once();
    bus_rd(2'd1, rv); chk("R9 halted cnt", rv, 0);
    // reload sweep
    foreach (rl[i]) begin
      int c, r;
      bit es;
      r = rl[i];
      bus_wr(2'd2, 1);
      // R4 enable with a tick in the same cycle
      bus_wr(2'd0, 32'h2000_0000 | r, 1'b1);
      bus_rd(2'd1, rv); chk("R4 load", rv, r);
      // R2 config readback, reserved bits zero
      bus_rd(2'd0, rv); chk("R2 cfg", rv, 32'h2000_0000 | r);
      c = r; es = 0;
      for (int k = 1; k <= 2 * r + 3; k++) begin
        tick_once();
        c = (c == 0) ? r : c - 1;
        if (c == 0) es = 1;
        bus_rd(2'd1, rv); chk("R5 R6 count", rv, c);
        bus_rd(2'd1, rv); chk("R5 tick low hold", rv, c);
        bus_rd(2'd2, rv); chk("R6 status", rv, {31'b0, es});
      end
      // R3 disable with a reload value in the same write
      bus_wr(2'd0, 32'h0000_0055);
      bus_rd(2'd0, rv); chk("R3 forced ones", rv, 32'h0000_FFFF);
      tick_once();
      bus_rd(2'd1, rv); chk("R9 hold after stop", rv, c);
    end
    // R2 reserved bits ignore writes (clear run first)
    bus_wr(2'd0, 32'hDFFF_0007);
    bus_rd(2'd0, rv); chk("R2 reserved ignored", rv, 32'h0000_0007);
    // R7 / R8
    bus_wr(2'd2, 1);
    bus_rd(2'd2, rv); chk("R7 cleared", rv, 0);
    bus_wr(2'd0, 32'h2000_0000);
    tick_once();
    bus_rd(2'd2, rv); chk("R6 reload0 expiry", rv, 1);
    chk("R8 irq masked", {31'b0, irq}, 0);
    bus_wr(2'd3, 1);
    chk("R8 irq on", {31'b0, irq}, 1);
    bus_wr(2'd2, 0);
    bus_rd(2'd2, rv); chk("R7 write0 no effect", rv, 1);
    bus_wr(2'd2, 1, 1'b1);
    bus_rd(2'd2, rv); chk("R7 set beats clear", rv, 1);
    bus_wr(2'd2, 1);
    bus_rd(2'd2, rv); chk("R7 clear", rv, 0);
    chk("R8 irq off", {31'b0, irq}, 0);
    bus_wr(2'd3, 0);
    bus_rd(2'd3, rv); chk("R8 ie readback", rv, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule